// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block folds the many interrupt sources of a multi-stream audio controller into one 32-bit summary word and one level-sensitive interrupt line. The sources are a response-ring status pair, a set of codec state-change flags, and three status flags for each of `NSTRM` streams. Each source has its own enable register inside the block. A global control register selects which summary bits may raise the line, and a master enable gates everything.

Software programs the enable registers and reads the summary word through a small synchronous-write, combinational-read register port. The summary word is recomputed every cycle from the live source inputs and registered, so the word and the line follow the sources one cycle late. The global summary bit reports pending work even when every enable is clear. It never drives the line by itself.

Stream indices below `NIN` are input streams and the rest are output streams. Each stream's control readback carries that direction.

Top module: `audio_irq_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every control register reads zero, the summary word is zero and `irq_o` is low.
- R2: Summary bit 30 (controller) is set when any bit of `ring_sts_i` ANDed with the ring enable register is set (bit 0 = response interrupt, bit 1 = overrun).
- R3: Summary bit 30 is also set when `codec_sts_i` ANDed with the wake-enable mask is nonzero.
- R4: Summary bit i (i < `NSTRM`) is set when stream i's three status flags, taken from `strm_sts_i[3i+2:3i]` (bit 0 = completion, bit 1 = FIFO error, bit 2 = descriptor error), ANDed with that stream's enable register are nonzero.
- R5: Summary bit 31 is set whenever any other summary bit is set, whatever the global control register holds.
- R6: `irq_o` is high only when global control bit 31 is set and the summary word ANDed with global control bits 30 and `NSTRM`-1:0 is nonzero. Otherwise it is low.
- R7: A change on a source input shows in `sts_o` and `irq_o` exactly one clock edge later.
- R8: Register map: address 0 is global control, where only bits 31, 30 and `NSTRM`-1:0 are writable and the rest read zero. Address 2 is the ring enable (bits 1:0), address 3 is the wake mask (bits `NCODEC`-1:0), and address 4+i is stream i's enable (bits 2:0).
- R9: Address 1 reads the summary word. Writes to address 1 and to addresses above 4+`NSTRM`-1 change no register.
- R10: Bit 3 of a stream enable readback is 1 when the stream index is below `NIN` (input stream) and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_sts_i | input | 2 | Response-ring status flags |
| codec_sts_i | input | NCODEC | Codec state-change flags |
| strm_sts_i | input | 3*NSTRM | Per-stream status flags, three per stream |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address for read and write |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| sts_o | output | 32 | Registered summary word |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
A table drives each source class on its own: the response and overrun ring flags against matching and mismatched enables, codec flags inside and outside the wake mask, and the lowest, a middle and the highest stream with chosen flag and enable pairs. This separates a wrong AND term from a wrong bit position. Further vectors keep the summary fixed and vary only the global control word: master enable off, the wrong stream enable, and the controller enable missing. These show that the summary bit 31 is set while the line stays low. Directed cases cover the reset state, write masking and unmapped addresses, the direction readback on both sides of `NIN`, and the one-edge latency from a source change.

// File: rtl/audio_irq_merge.sv
module audio_irq_merge #(
  parameter int NSTRM  = 8,
  parameter int NIN    = 4,
  parameter int NCODEC = 15,
  parameter int AW     = $clog2(NSTRM + 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ring_sts_i,
  input  logic [NCODEC-1:0]    codec_sts_i,
  input  logic [3*NSTRM-1:0]   strm_sts_i,
  input  logic                 cfg_we,
  input  logic [AW-1:0]        cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output logic [31:0]          sts_o,
  output logic                 irq_o
);

  localparam int          CTRL_BIT  = 30;
  localparam int          GLB_BIT   = 31;
  localparam logic [31:0] STRM_MASK = (32'h1 << NSTRM) - 32'h1;
  localparam logic [31:0] GCTL_MASK = STRM_MASK | 32'hC000_0000;
  localparam logic [AW-1:0] A_GCTL  = AW'(0);
  localparam logic [AW-1:0] A_STS   = AW'(1);
  localparam logic [AW-1:0] A_RING  = AW'(2);
  localparam logic [AW-1:0] A_WAKE  = AW'(3);
  localparam int          A_STRM0   = 4;

  logic [31:0]       gctl_q;
  logic [1:0]        ring_ctl_q;
  logic [NCODEC-1:0] wake_q;
  logic [2:0]        sctl_q [NSTRM];
  logic [NSTRM-1:0]  strm_hit;
  logic [NSTRM-1:0]  strm_dir;
  logic              ctrl_hit;
  logic [31:0]       sts_next;
  logic [31:0]       sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q     <= '0;
      ring_ctl_q <= '0;
      wake_q     <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_GCTL) gctl_q     <= cfg_wdata & GCTL_MASK;
      if (cfg_addr == A_RING) ring_ctl_q <= cfg_wdata[1:0];
      if (cfg_addr == A_WAKE) wake_q     <= cfg_wdata[NCODEC-1:0];
    end
  end

  for (genvar i = 0; i < NSTRM; i++) begin : g_strm
    localparam logic [AW-1:0] MY_ADDR = AW'(A_STRM0 + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             sctl_q[i] <= '0;
      else if (cfg_we && cfg_addr == MY_ADDR) sctl_q[i] <= cfg_wdata[2:0];
    end

    assign strm_hit[i] = |(strm_sts_i[3*i +: 3] & sctl_q[i]);
    assign strm_dir[i] = (i < NIN);

    a_r4_strm_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (sts_o[i] == $past(|(strm_sts_i[3*i +: 3] & sctl_q[i]))));
  end

  assign ctrl_hit = (|(ring_sts_i & ring_ctl_q)) | (|(codec_sts_i & wake_q));

  always_comb begin
    sts_next                = '0;
    sts_next[NSTRM-1:0]     = strm_hit;
    sts_next[CTRL_BIT]      = ctrl_hit;
    sts_next[GLB_BIT]       = ctrl_hit | (|strm_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_next;
  end

  assign sts_o = sts_q;
  assign irq_o = gctl_q[GLB_BIT] & (|(sts_q[CTRL_BIT:0] & gctl_q[CTRL_BIT:0]));

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_GCTL:  cfg_rdata = gctl_q;
      A_STS:   cfg_rdata = sts_q;
      A_RING:  cfg_rdata[1:0] = ring_ctl_q;
      A_WAKE:  cfg_rdata[NCODEC-1:0] = wake_q;
      default: begin
        for (int i = 0; i < NSTRM; i++)
          if (cfg_addr == AW'(A_STRM0 + i))
            cfg_rdata[3:0] = {strm_dir[i], sctl_q[i]};
      end
    endcase
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (sts_o == 32'h0 && !irq_o));

  a_r2_ring_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(|(ring_sts_i & ring_ctl_q))) |-> sts_o[CTRL_BIT]);

  a_r3_codec_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(|(codec_sts_i & wake_q))) |-> sts_o[CTRL_BIT]);

  a_r5_global_any: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(|(ring_sts_i & ring_ctl_q))) |-> sts_o[GLB_BIT]);

  a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !gctl_q[GLB_BIT] |-> !irq_o);

endmodule

// File: tb/audio_irq_merge_tb_top.sv
`timescale 1ns/1ps
module audio_irq_merge_tb_top;
  localparam int NSTRM = 8, NIN = 4, NCODEC = 15;
  localparam int AW = $clog2(NSTRM + 4);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ring_sts = '0;
  logic [NCODEC-1:0] codec_sts = '0;
  logic [3*NSTRM-1:0] strm_sts = '0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, sts_o;
  logic irq_o;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  audio_irq_merge #(.NSTRM(NSTRM), .NIN(NIN), .NCODEC(NCODEC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ring_sts_i(ring_sts), .codec_sts_i(codec_sts),
    .strm_sts_i(strm_sts), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sts_o(sts_o), .irq_o(irq_o));

  typedef struct packed {
    logic [31:0] gctl; logic [1:0] rctl; logic [1:0] rsts;
    logic [14:0] wake; logic [14:0] csts;
    logic [2:0] sidx; logic [2:0] sctl; logic [2:0] ssts;
    logic [31:0] exp_sts; logic exp_irq;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{32'hC000_0000, 2'b00, 2'b00, 15'h0, 15'h0, 3'd0, 3'b000, 3'b000, 32'h0000_0000, 1'b0}, // idle
    '{32'hC000_0000, 2'b01, 2'b01, 15'h0, 15'h0, 3'd0, 3'b000, 3'b000, 32'hC000_0000, 1'b1}, // R2 response
    '{32'hC000_0000, 2'b01, 2'b10, 15'h0, 15'h0, 3'd0, 3'b000, 3'b000, 32'h0000_0000, 1'b0}, // R2 mismatch
    '{32'h0000_0000, 2'b10, 2'b10, 15'h0, 15'h0, 3'd0, 3'b000, 3'b000, 32'hC000_0000, 1'b0}, // R5 no enables
    '{32'h8000_0000, 2'b00, 2'b00, 15'h4, 15'h4, 3'd0, 3'b000, 3'b000, 32'hC000_0000, 1'b0}, // R3, R6 no CIE
    '{32'hC000_0000, 2'b00, 2'b00, 15'h3, 15'h4, 3'd0, 3'b000, 3'b000, 32'h0000_0000, 1'b0}, // R3 masked
    '{32'h8000_0001, 2'b00, 2'b00, 15'h0, 15'h0, 3'd0, 3'b001, 3'b001, 32'h8000_0001, 1'b1}, // R4 stream 0
    '{32'h8000_0080, 2'b00, 2'b00, 15'h0, 15'h0, 3'd7, 3'b110, 3'b100, 32'h8000_0080, 1'b1}, // R4 stream 7
    '{32'h8000_0080, 2'b00, 2'b00, 15'h0, 15'h0, 3'd7, 3'b011, 3'b100, 32'h0000_0000, 1'b0}, // R4 masked
    '{32'h8000_0001, 2'b00, 2'b00, 15'h0, 15'h0, 3'd3, 3'b010, 3'b010, 32'h8000_0008, 1'b0}, // R6 wrong enable
    '{32'h0000_0008, 2'b00, 2'b00, 15'h0, 15'h0, 3'd3, 3'b010, 3'b010, 32'h8000_0008, 1'b0}, // R6 no master
    '{32'hC000_0008, 2'b00, 2'b00, 15'h0, 15'h0, 3'd3, 3'b010, 3'b010, 32'h8000_0008, 1'b1}  // R6 pass
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); cfg_addr = AW'(a); #1; d = cfg_rdata;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    chk("R1 status in reset", sts_o, 32'h0);
    rst_n = 1'b1;
    rd(0, rv); chk("R1 gctl after reset", rv, 32'h0);
    rd(4 + 5, rv); chk("R1 stream ctl after reset", rv & 32'h7, 32'h0);

    for (int v = 0; v < 12; v++) begin
      for (int s = 0; s < NSTRM; s++) wr(4 + s, 32'h0);
      wr(4 + TBL[v].sidx, {29'b0, TBL[v].sctl});
      wr(0, TBL[v].gctl);
      wr(2, {30'b0, TBL[v].rctl});
      wr(3, {17'b0, TBL[v].wake});
      @(negedge clk);
      ring_sts = TBL[v].rsts;
      codec_sts = TBL[v].csts;
      strm_sts = '0;
      strm_sts[3*TBL[v].sidx +: 3] = TBL[v].ssts;
      @(negedge clk); @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 status vec %0d", v), sts_o, TBL[v].exp_sts);
      chk($sformatf("R6 irq vec %0d", v), {31'b0, irq_o}, {31'b0, TBL[v].exp_irq});
      rd(1, rv); chk($sformatf("R9 status read vec %0d", v), rv, TBL[v].exp_sts);
    end

    // R8 write masking
    wr(0, 32'hFFFF_FFFF); rd(0, rv); chk("R8 gctl mask", rv, 32'hC000_00FF);
    wr(2, 32'hFFFF_FFFF); rd(2, rv); chk("R8 ring ctl mask", rv, 32'h3);
    wr(3, 32'hFFFF_FFFF); rd(3, rv); chk("R8 wake mask", rv, 32'h7FFF);

    // R10 direction bit
    wr(4 + 3, 32'h0); rd(4 + 3, rv); chk("R10 stream 3 input", rv, 32'h8);
    wr(4 + 4, 32'h5); rd(4 + 4, rv); chk("R10 stream 4 output", rv, 32'h5);

    // R9 ignored writes
    ring_sts = '0; codec_sts = '0; strm_sts = '0;
    wr(0, 32'h0); wr(2, 32'h0); wr(3, 32'h0);
    for (int s = 0; s < NSTRM; s++) wr(4 + s, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    wr(12, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    @(negedge clk);
    rd(1, rv); chk("R9 status unchanged", rv, 32'h0);
    rd(0, rv); chk("R9 gctl unchanged", rv, 32'h0);
    rd(2, rv); chk("R9 ring unchanged", rv, 32'h0);
    rd(3, rv); chk("R9 wake unchanged", rv, 32'h0);
    for (int s = 0; s < NSTRM; s++) begin
      rd(4 + s, rv); chk($sformatf("R9 stream %0d unchanged", s), rv & 32'h7, 32'h0);
    end
    rd(12, rv); chk("R9 unmapped reads zero", rv, 32'h0);

    // R7 latency
    wr(0, 32'hC000_0000); wr(2, 32'h1);
    @(negedge clk); ring_sts = 2'b01; #1;
    chk("R7 status before edge", sts_o, 32'h0);
    chk("R7 irq before edge", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R7 status after one edge", sts_o, 32'hC000_0000);
    chk("R7 irq after one edge", {31'b0, irq_o}, 32'h1);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 irq on reset", {31'b0, irq_o}, 32'h0);
    chk("R1 status on reset", sts_o, 32'h0);
    @(negedge clk); rst_n = 1'b1; ring_sts = '0;
    rd(0, rv); chk("R1 gctl cleared", rv, 32'h0);
    rd(2, rv); chk("R1 ring cleared", rv, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule